// File: doc/BRIEF.md
# Second-Aligned Reference Phase Generator

This block produces the angular position of a reference sinusoid as an unsigned fixed-point word in which the full word range is one turn. On every local sample tick, a fast path advances the phase by a frequency step. That step is the nominal frequency word multiplied by a slowly reloaded factor that cancels the local clock's fractional error. The phase is integrated with the trapezoidal rule, so each advance is the mean of the present step and the step used at the previous tick.

A slow path keeps the phase tied to an external one-pulse-per-second input. On each rising edge of that pulse it captures the raw accumulator as a signed offset from the ideal value of zero. It then averages the most recent offsets with a recursive moving average: a circular history, and a running sum that adds the newest value and drops the oldest. The averaged offset is held in a correction register. It is subtracted from the accumulator until the next pulse edge. Until the history has filled, the correction stays at zero and the lock indication stays low.

Top module: `pps_phase_disc`

## Requirements
- R1: While reset is asserted, and before any tick or pulse edge after it, phase_out is 0 and locked is 0.
- R2: The effective step is floor(freq_word * scale_word / 2^30), truncated to 32 bits. scale_word is unsigned with 30 fraction bits, so 2^30 means a factor of one. A change of freq_word or scale_word is first used one clock after it is presented.
- R3: On a clock with tick high, the accumulator grows by floor((present step + step used at the previous tick) / 2), and that previous step is 0 after reset. Without tick, the accumulator does not change.
- R4: The accumulator and phase_out wrap modulo 2^32.
- R5: A capture happens on a clock where pps is high and was low on the clock before. It records the accumulator value from before that clock's update as a signed 32-bit offset. A pulse held high for several clocks captures once.
- R6: Before DEPTH captures have been made (DEPTH = 2^HIST_LOG2), the correction is 0 and locked stays low.
- R7: At the DEPTH-th capture and at every later one, the correction becomes floor of the mean of the last DEPTH offsets, and locked rises and stays high. Both are visible from the clock after the edge.
- R8: phase_out equals accumulator minus correction modulo 2^32. The correction does not change between captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick | input | 1 | Sample-rate enable for the fast path |
| pps | input | 1 | One-pulse-per-second level input, already in the clock domain |
| freq_word | input | 32 | Nominal phase step per tick (full turn = 2^32) |
| scale_word | input | 32 | Clock-error correction factor, 30 fraction bits |
| phase_out | output | 32 | Corrected phase word |
| locked | output | 1 | High once the offset history has filled |

## Verification
The bench builds the block with HIST_LOG2 = 4, a 16-entry history. With that depth, the fill-up boundary, the first averaged correction and many later wraps of the circular history all fall inside a run of a few thousand clocks, with pulse edges a few tens of clocks apart. The 32-bit phase and the 30-bit scale fraction keep their default values. This lets the bench drive a 20 ppm scaled step, an accumulator wrap and signed averaging of offsets on either side of zero at full width.

// File: rtl/pdpa_pkg.sv
package pdpa_pkg;
  localparam int unsigned PHASE_W_DEF    = 32;
  localparam int unsigned SCALE_W_DEF    = 32;
  localparam int unsigned SCALE_FRAC_DEF = 30;
  localparam int unsigned HIST_LOG2_DEF  = 7;

  typedef enum logic {
    AVG_FILLING = 1'b0,
    AVG_LOCKED  = 1'b1
  } avg_state_e;
endpackage

// File: rtl/pdpa_step_scaler.sv
module pdpa_step_scaler #(
  parameter int unsigned PHASE_W    = 32,
  parameter int unsigned SCALE_W    = 32,
  parameter int unsigned SCALE_FRAC = 30
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] freq_word,
  input  logic [SCALE_W-1:0] scale_word,
  output logic [PHASE_W-1:0] step
);
  localparam int unsigned PROD_W = PHASE_W + SCALE_W;

  logic [PROD_W-1:0]  prod;
  logic [PHASE_W-1:0] step_d;

  always_comb begin
    prod   = PROD_W'(freq_word) * PROD_W'(scale_word);
    step_d = prod[SCALE_FRAC +: PHASE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step <= '0;
    else        step <= step_d;
  end
endmodule

// File: rtl/pdpa_integrator.sv
module pdpa_integrator #(
  parameter int unsigned PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [PHASE_W-1:0] step,
  output logic [PHASE_W-1:0] acc
);
  logic [PHASE_W-1:0] prev_step, prev_step_d, acc_d;
  logic [PHASE_W:0]   pair_sum;

  always_comb begin
    pair_sum    = {1'b0, step} + {1'b0, prev_step};
    acc_d       = acc;
    prev_step_d = prev_step;
    if (tick) begin
      acc_d       = acc + pair_sum[PHASE_W:1];
      prev_step_d = step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      prev_step <= '0;
    end else begin
      acc       <= acc_d;
      prev_step <= prev_step_d;
    end
  end

  p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(acc));
endmodule

// File: rtl/pdpa_edge_capture.sv
module pdpa_edge_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic pps,
  output logic cap
);
  logic pps_q;

  always_comb cap = pps & ~pps_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pps_q <= 1'b0;
    else        pps_q <= pps;
  end
endmodule

// File: rtl/pdpa_offset_avg.sv
module pdpa_offset_avg
  import pdpa_pkg::*;
#(
  parameter int unsigned WIDTH     = 32,
  parameter int unsigned HIST_LOG2 = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap,
  input  logic [WIDTH-1:0] sample,
  output logic [WIDTH-1:0] corr,
  output logic             locked
);
  localparam int unsigned DEPTH = 1 << HIST_LOG2;
  localparam int unsigned SUM_W = WIDTH + HIST_LOG2 + 1;
  localparam int unsigned CNT_W = HIST_LOG2 + 1;

  logic [WIDTH-1:0]        hist [DEPTH];
  logic [HIST_LOG2-1:0]    wptr, wptr_d;
  logic [CNT_W-1:0]        fill, fill_d;
  logic signed [SUM_W-1:0] run_sum, run_sum_d, newest, oldest, mean;
  logic [WIDTH-1:0]        corr_d;
  avg_state_e              state, state_d;
  logic                    full, fills_now;

  always_comb begin
    full      = (fill == CNT_W'(DEPTH));
    newest    = SUM_W'($signed(sample));
    oldest    = full ? SUM_W'($signed(hist[wptr])) : '0;
    run_sum_d = run_sum;
    wptr_d    = wptr;
    fill_d    = fill;
    if (cap) begin
      run_sum_d = run_sum + newest - oldest;
      wptr_d    = wptr + 1'b1;
      if (!full) fill_d = fill + 1'b1;
    end
    fills_now = cap && (fill_d == CNT_W'(DEPTH));
    mean      = run_sum_d >>> HIST_LOG2;
    corr_d    = fills_now ? mean[WIDTH-1:0] : corr;
    state_d   = fills_now ? AVG_LOCKED : state;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      fill    <= '0;
      run_sum <= '0;
      corr    <= '0;
      state   <= AVG_FILLING;
    end else begin
      wptr    <= wptr_d;
      fill    <= fill_d;
      run_sum <= run_sum_d;
      corr    <= corr_d;
      state   <= state_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap) hist[wptr] <= sample;
  end

  always_comb locked = (state == AVG_LOCKED);

  p_unlocked_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (corr == '0));
  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
endmodule

// File: rtl/pps_phase_disc.sv
module pps_phase_disc
  import pdpa_pkg::*;
#(
  parameter int unsigned PHASE_W    = PHASE_W_DEF,
  parameter int unsigned SCALE_W    = SCALE_W_DEF,
  parameter int unsigned SCALE_FRAC = SCALE_FRAC_DEF,
  parameter int unsigned HIST_LOG2  = HIST_LOG2_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               pps,
  input  logic [PHASE_W-1:0] freq_word,
  input  logic [SCALE_W-1:0] scale_word,
  output logic [PHASE_W-1:0] phase_out,
  output logic               locked
);
  logic               rst_meta, rst_sync;
  logic [PHASE_W-1:0] step, acc, corr;
  logic               cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  pdpa_step_scaler #(.PHASE_W(PHASE_W), .SCALE_W(SCALE_W), .SCALE_FRAC(SCALE_FRAC)) u_scale (
    .clk(clk), .rst_n(rst_sync), .freq_word(freq_word), .scale_word(scale_word), .step(step));

  pdpa_integrator #(.PHASE_W(PHASE_W)) u_integ (
    .clk(clk), .rst_n(rst_sync), .tick(tick), .step(step), .acc(acc));

  pdpa_edge_capture u_edge (
    .clk(clk), .rst_n(rst_sync), .pps(pps), .cap(cap));

  pdpa_offset_avg #(.WIDTH(PHASE_W), .HIST_LOG2(HIST_LOG2)) u_avg (
    .clk(clk), .rst_n(rst_sync), .cap(cap), .sample(acc), .corr(corr), .locked(locked));

  always_comb phase_out = acc - corr;

  p_corr_between_edges_r8: assert property (@(posedge clk) disable iff (!rst_sync)
    !cap |=> $stable(corr));
  p_held_pulse_once_r5: assert property (@(posedge clk) disable iff (!rst_sync)
    $past(pps) && pps |-> !cap);
endmodule

// File: tb/tb_pps_phase_disc.sv
module tb_pps_phase_disc;
  localparam int CLK_PERIOD = 10;
  localparam int LOG2 = 4;
  localparam int DEPTH = 1 << LOG2;
  localparam logic [31:0] ONE = 32'h4000_0000;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, pps = 1'b0;
  logic [31:0] freq_word = 32'd1000, scale_word = ONE;
  logic [31:0] phase_out;
  logic locked;
  int checks = 0, errors = 0;
  bit cmp_on = 1'b0, done = 1'b0;

  pps_phase_disc #(.HIST_LOG2(LOG2)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pps(pps), .freq_word(freq_word),
    .scale_word(scale_word), .phase_out(phase_out), .locked(locked));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  logic [31:0] m_step, m_prev, m_acc, m_corr;
  logic m_pps_q, m_lock;
  longint offs[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_step <= 0; m_prev <= 0; m_acc <= 0; m_corr <= 0; m_pps_q <= 0; m_lock <= 0;
      offs.delete();
    end else begin
      longint unsigned p;
      p = longint'(freq_word) * longint'(scale_word);
      m_step <= 32'(p >> 30);
      if (tick) begin
        m_acc  <= 32'(longint'(m_acc) + ((longint'(m_step) + longint'(m_prev)) >> 1));
        m_prev <= m_step;
      end
      m_pps_q <= pps;
      if (pps && !m_pps_q) begin
        offs.push_back(longint'($signed(m_acc)));
        if (offs.size() > DEPTH) void'(offs.pop_front());
        if (offs.size() == DEPTH) begin
          longint s;
          s = 0;
          foreach (offs[i]) s += offs[i];
          m_corr <= 32'(s >>> LOG2);
          m_lock <= 1'b1;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk("R3 R4 R8 phase vs model", phase_out, m_acc - m_corr);
    chk("R6 R7 locked vs model", {31'd0, locked}, {31'd0, m_lock});
  end

  task automatic clk1(); @(negedge clk); endtask

  int edges = 0;
  task automatic pulse(input int hold);
    pps = 1'b1;
    repeat (hold) clk1();
    pps = 1'b0;
    edges++;
  endtask

  initial begin
    logic [31:0] p2, p3, e_step;
    repeat (3) clk1();
    chk("R1 phase in reset", phase_out, 32'd0);
    chk("R1 locked in reset", {31'd0, locked}, 32'd0);
    rst_n = 1'b1;
    repeat (5) clk1();
    chk("R1 phase after release", phase_out, 32'd0);
    cmp_on = 1'b1;
    // R3: first tick adds half a step, then a full step
    tick = 1'b1; clk1(); tick = 1'b0;
    chk("R3 first trapezoid tick", phase_out, 32'd500);
    repeat (3) clk1();
    chk("R3 no change without tick", phase_out, 32'd500);
    tick = 1'b1; clk1(); tick = 1'b0;
    chk("R3 second tick", phase_out, 32'd1500);
    // R2: 20 ppm scaled 1.8 degree step
    freq_word = 32'd21474836; scale_word = 32'd1073720349;
    repeat (2) clk1();
    tick = 1'b1; clk1(); clk1(); p2 = phase_out; clk1(); p3 = phase_out; tick = 1'b0;
    e_step = 32'((64'd21474836 * 64'd1073720349) >> 30);
    chk("R2 scaled step", p3 - p2, e_step);
    chk("R2 step below nominal", {31'd0, e_step < 32'd21474836}, 32'd1);
    // R4: large step wraps
    freq_word = 32'hC000_0000; scale_word = ONE;
    repeat (2) clk1();
    tick = 1'b1; clk1(); clk1(); p2 = phase_out; clk1(); p3 = phase_out; tick = 1'b0;
    chk("R4 wrap step", p3 - p2, 32'hC000_0000);
    freq_word = 32'd21474836; scale_word = 32'd1073720349;
    // R5 R6 R7: build the history with mixed pulse widths
    for (int k = 0; k < 60; k++) begin
      int gap;
      gap = 10 + int'($urandom_range(0, 25));
      for (int c = 0; c < gap; c++) begin
        tick = ($urandom_range(0, 1) == 1);
        clk1();
      end
      tick = 1'b0;
      if (k % 7 == 3) scale_word = 32'd1073741824 - 32'($urandom_range(0, 40000));
      if (k % 11 == 5) freq_word = 32'($urandom_range(1, 400000000));
      pulse(1 + (k % 4));
      clk1();
      if (edges == DEPTH - 1) chk("R6 not locked before fill", {31'd0, locked}, 32'd0);
      if (edges == DEPTH - 1) chk("R6 zero correction before fill", phase_out, m_acc);
      if (edges == DEPTH) chk("R7 locked at fill", {31'd0, locked}, 32'd1);
      if (edges == DEPTH + 3) begin
        p2 = phase_out;
        repeat (5) clk1();
        chk("R8 correction held without tick or edge", phase_out, p2);
      end
    end
    chk("R5 one capture per pulse", 32'(offs.size()), 32'(DEPTH));
    cmp_on = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule